// File: doc/BRIEF.md
# Shadow-Selected Management Register Bank

This block sits behind a single management register address and fans it out into several 10-bit shadow registers. Every 16-bit write carries three fields: bit 15 is a write flag, bits [14:10] name a shadow, and bits [9:0] are a payload. When the flag is set, the named shadow takes the payload. When the flag is clear, the block only remembers the named shadow, and the next read returns that shadow's contents. Read data therefore depends on earlier writes: software first points the slot at a shadow and then reads it.

One shadow, the spare-control shadow, has a single writable bit and several reserved bits that read back as fixed values. Its writable bit steers the interrupt output pin between the normal interrupt source and an energy-detect source. A parameterised run of general-purpose shadows provides plain 10-bit storage. Any other selector value reads as zero and swallows writes. The serial management framing is handled elsewhere, so the block sees single-cycle parallel read and write strobes.

Top module: `shdw_reg_bank`

## Requirements
- R1: After reset the latched selector is 5'b00100 and the spare shadow's writable bit is 0, so a read with no prior write returns 16'h100C, and irq_out follows irq_in.
- R2: A write with wr_data[15]=1 stores wr_data[9:0] in the general-purpose shadow named by wr_data[14:10] (selectors GP_BASE to GP_BASE+NUM_GP-1).
- R3: A write with wr_data[15]=0 changes no shadow payload. It only latches wr_data[14:10] as the selector for later reads.
- R4: Read data carries the latched shadow's payload in bits [9:0], echoes the latched selector in bits [14:10], and has bit 15 at 0.
- R5: In the spare shadow (selector 5'b00100) bits [9:5] read 0, bits [4:2] read 3'b011 and bit 0 reads 0, whatever value was written.
- R6: Spare shadow bit 1 resets to 0 and is writable. When it is 1, irq_out equals energy_det. When it is 0, irq_out equals irq_in.
- R7: A selector that names neither the spare shadow nor a general-purpose shadow reads as payload 0, and writes to it have no effect.
- R8: rd_valid is high for exactly the cycle after an rd_en pulse. rd_data is 0 whenever rd_valid is low.
- R9: When wr_en and rd_en are high in the same cycle, the write takes effect first and the read data on the next cycle reflects it.
- R10: A write with wr_data[15]=1 leaves the latched read selector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 16 | Write word: flag, selector, payload |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 16 | Read word: 0, latched selector, payload |
| irq_in | input | 1 | Normal interrupt source |
| energy_det | input | 1 | Energy-detect source |
| irq_out | output | 1 | Interrupt pin after the source mux |

## Verification
The bench builds the bank with three general-purpose shadows starting at selector 16 instead of the default two at selector 8. The run then moves away from the spare selector and reaches the last general-purpose slot, so an off-by-one in the range decode becomes visible. The unimplemented selector 19 sits directly past that range and can be probed the same way. Selector 3, which sits just below the spare shadow, is probed as well.

// File: rtl/shdw_pkg.sv
package shdw_pkg;
   localparam int WORD_W = 16;
   localparam int SEL_W  = 5;
   localparam int PAY_W  = 10;

   typedef struct packed {
      logic             wflag;
      logic [SEL_W-1:0] sel;
      logic [PAY_W-1:0] pay;
   } shdw_cmd_t;
endpackage

// File: rtl/shdw_cmd_decode.sv
module shdw_cmd_decode
   import shdw_pkg::*;
#(
   parameter int NUM_GP    = 2,
   parameter int GP_BASE   = 8,
   parameter int SPARE_SEL = 4
) (
   input  logic                     wr_en,
   input  logic [WORD_W-1:0]        wr_data,
   output shdw_cmd_t                cmd,
   output logic                     sel_we,
   output logic                     spare_we,
   output logic [NUM_GP-1:0]        gp_we
);
   assign cmd      = shdw_cmd_t'(wr_data);
   assign sel_we   = wr_en & ~cmd.wflag;
   assign spare_we = wr_en & cmd.wflag & (cmd.sel == SEL_W'(SPARE_SEL));

   for (genvar g = 0; g < NUM_GP; g++) begin : g_hit
      assign gp_we[g] = wr_en & cmd.wflag & (cmd.sel == SEL_W'(GP_BASE + g));
   end
endmodule

// File: rtl/shdw_masked_reg.sv
module shdw_masked_reg #(
   parameter int              W        = 10,
   parameter logic [W-1:0]    RW_MASK  = '1,
   parameter logic [W-1:0]    FIXED    = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);
   logic [W-1:0] stor_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stor_q <= '0;
      else if (we) stor_q <= wdata & RW_MASK;
   end

   assign q = (stor_q & RW_MASK) | (FIXED & ~RW_MASK);
endmodule

// File: rtl/shdw_pin_mux.sv
module shdw_pin_mux (
   input  logic use_alt,
   input  logic norm_src,
   input  logic alt_src,
   output logic pin_out
);
   assign pin_out = use_alt ? alt_src : norm_src;
endmodule

// File: rtl/shdw_reg_bank.sv
module shdw_reg_bank
   import shdw_pkg::*;
#(
   parameter int             NUM_GP      = 2,
   parameter int             GP_BASE     = 8,
   parameter int             SPARE_SEL   = 4,
   parameter logic [9:0]     SPARE_FIXED = 10'h00C,
   parameter int             ED_BIT      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [15:0]       rd_data,
   input  logic              irq_in,
   input  logic              energy_det,
   output logic              irq_out
);
   localparam logic [PAY_W-1:0] SPARE_RW = PAY_W'(1) << ED_BIT;
   localparam int               SEL_MAX  = (1 << SEL_W) - 1;

   if (NUM_GP < 1 || GP_BASE < 0 || GP_BASE + NUM_GP - 1 > SEL_MAX) begin : g_bad_range
      $error("shdw_reg_bank: general-purpose selector range out of bounds");
   end
   if (SPARE_SEL >= GP_BASE && SPARE_SEL < GP_BASE + NUM_GP) begin : g_bad_overlap
      $error("shdw_reg_bank: spare selector overlaps general-purpose range");
   end
   if (ED_BIT < 0 || ED_BIT >= PAY_W || SPARE_SEL > SEL_MAX) begin : g_bad_spare
      $error("shdw_reg_bank: spare shadow parameters out of range");
   end

   shdw_cmd_t          cmd;
   logic               sel_we;
   logic               spare_we;
   logic [NUM_GP-1:0]  gp_we;
   logic [SEL_W-1:0]   sel_q;
   logic [PAY_W-1:0]   spare_q;
   logic [PAY_W-1:0]   gp_q [NUM_GP];
   logic [PAY_W-1:0]   rd_pay;

   shdw_cmd_decode #(
      .NUM_GP    (NUM_GP),
      .GP_BASE   (GP_BASE),
      .SPARE_SEL (SPARE_SEL)
   ) u_dec (
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cmd      (cmd),
      .sel_we   (sel_we),
      .spare_we (spare_we),
      .gp_we    (gp_we)
   );

   shdw_masked_reg #(
      .W       (PAY_W),
      .RW_MASK (SPARE_RW),
      .FIXED   (SPARE_FIXED)
   ) u_spare (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (spare_we),
      .wdata (cmd.pay),
      .q     (spare_q)
   );

   for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
      shdw_masked_reg #(
         .W       (PAY_W),
         .RW_MASK ({PAY_W{1'b1}}),
         .FIXED   ('0)
      ) u_gp (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (gp_we[g]),
         .wdata (cmd.pay),
         .q     (gp_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= SEL_W'(SPARE_SEL);
         rd_valid <= 1'b0;
      end else begin
         if (sel_we) sel_q <= cmd.sel;
         rd_valid <= rd_en;
      end
   end

   always_comb begin
      rd_pay = '0;
      if (sel_q == SEL_W'(SPARE_SEL)) rd_pay = spare_q;
      for (int i = 0; i < NUM_GP; i++) begin
         if (sel_q == SEL_W'(GP_BASE + i)) rd_pay = gp_q[i];
      end
   end

   assign rd_data = rd_valid ? {1'b0, sel_q, rd_pay} : '0;

   shdw_pin_mux u_irq (
      .use_alt  (spare_q[ED_BIT]),
      .norm_src (irq_in),
      .alt_src  (energy_det),
      .pin_out  (irq_out)
   );
endmodule

// File: rtl/shdw_reg_bank_chk.sv
module shdw_reg_bank_chk #(
   parameter int         NUM_GP      = 2,
   parameter int         GP_BASE     = 8,
   parameter int         SPARE_SEL   = 4,
   parameter logic [9:0] SPARE_FIXED = 10'h00C,
   parameter int         ED_BIT      = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic        rd_en,
   input logic        rd_valid,
   input logic [15:0] rd_data,
   input logic        irq_in,
   input logic        energy_det,
   input logic        irq_out,
   input logic [4:0]  sel_q
);
   localparam logic [9:0] RSV_MASK = ~(10'(1) << ED_BIT);

   logic rd_spare;
   logic rd_unimpl;
   assign rd_spare  = rd_data[14:10] == 5'(SPARE_SEL);
   assign rd_unimpl = !rd_spare &&
                      (int'(rd_data[14:10]) < GP_BASE || int'(rd_data[14:10]) >= GP_BASE + NUM_GP);

   AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);                                                   // R8
   AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);                                                 // R8
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == 16'h0000);                                    // R8
   AST_RD_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !rd_data[15]);                                            // R4
   AST_SPARE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_spare) |-> (rd_data[9:0] & RSV_MASK) == (SPARE_FIXED & RSV_MASK)); // R5
   AST_IRQ_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_spare && rd_data[ED_BIT]) |-> irq_out == energy_det);  // R6
   AST_IRQ_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_spare && !rd_data[ED_BIT]) |-> irq_out == irq_in);     // R6
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_unimpl) |-> rd_data[9:0] == 10'h000);                  // R7
   AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[15]) |=> $stable(sel_q));                            // R10
   AST_SEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[15]) |=> sel_q == $past(wr_data[14:10]));           // R3
endmodule

bind shdw_reg_bank shdw_reg_bank_chk #(
   .NUM_GP      (NUM_GP),
   .GP_BASE     (GP_BASE),
   .SPARE_SEL   (SPARE_SEL),
   .SPARE_FIXED (SPARE_FIXED),
   .ED_BIT      (ED_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .irq_in     (irq_in),
   .energy_det (energy_det),
   .irq_out    (irq_out),
   .sel_q      (sel_q)
);

// File: tb/tb_shdw_reg_bank.sv
module tb_shdw_reg_bank;
   localparam int NGP   = 3;
   localparam int GBASE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        irq_in = 1'b0;
   logic        energy_det = 1'b0;
   logic        irq_out;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   shdw_reg_bank #(.NUM_GP(NGP), .GP_BASE(GBASE)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
      .irq_in(irq_in), .energy_det(energy_det), .irq_out(irq_out)
   );

   function automatic logic [15:0] wword(input logic flag, input int sel, input logic [9:0] pay);
      return {flag, 5'(sel), pay};
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_read(input logic [15:0] exp, input string req);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b1, {req, " rd_valid"}, {15'b0, rd_valid}, 16'h0001);
      check(rd_data === exp, req, rd_data, exp);
   endtask

   task automatic t_reset;
      irq_in = 1'b1; energy_det = 1'b0;
      @(negedge clk);
      check(irq_out === 1'b1, "R1 irq follows irq_in", {15'b0, irq_out}, 16'h0001);
      do_read(16'h100C, "R1 reset read");
   endtask

   task automatic t_gp_write;
      do_write(wword(1, 16, 10'h2A5));
      do_write(wword(1, 17, 10'h15A));
      do_write(wword(1, 18, 10'h3FF));
      do_write(wword(0, 16, 10'h000));
      do_read(wword(0, 16, 10'h2A5), "R2 R4 gp16");
      do_write(wword(0, 17, 10'h000));
      do_read(wword(0, 17, 10'h15A), "R2 gp17");
      do_write(wword(0, 18, 10'h000));
      do_read(wword(0, 18, 10'h3FF), "R2 gp18 last slot");
   endtask

   task automatic t_select_only;
      do_write(wword(0, 16, 10'h155));
      do_read(wword(0, 16, 10'h2A5), "R3 select write keeps payload");
   endtask

   task automatic t_sel_hold;
      do_write(wword(1, 17, 10'h001));
      do_read(wword(0, 16, 10'h2A5), "R10 enable write keeps selector");
      do_write(wword(0, 17, 10'h000));
      do_read(wword(0, 17, 10'h001), "R10 gp17 updated");
   endtask

   task automatic t_spare;
      do_write(wword(1, 4, 10'h3FD));
      do_write(wword(0, 4, 10'h000));
      do_read(16'h100C, "R5 reserved bits fixed");
      do_write(wword(1, 4, 10'h3FF));
      do_read(16'h100E, "R5 R6 bit1 set");
   endtask

   task automatic t_irq;
      irq_in = 1'b0; energy_det = 1'b1;
      @(negedge clk);
      check(irq_out === 1'b1, "R6 alt source high", {15'b0, irq_out}, 16'h0001);
      irq_in = 1'b1; energy_det = 1'b0;
      @(negedge clk);
      check(irq_out === 1'b0, "R6 alt source low", {15'b0, irq_out}, 16'h0000);
      do_write(wword(1, 4, 10'h000));
      check(irq_out === 1'b1, "R6 back to irq_in", {15'b0, irq_out}, 16'h0001);
      do_read(16'h100C, "R6 bit1 cleared");
   endtask

   task automatic t_unimpl;
      do_write(wword(1, 19, 10'h3FF));
      do_write(wword(0, 19, 10'h000));
      do_read(wword(0, 19, 10'h000), "R7 sel19 reads zero");
      do_write(wword(1, 3, 10'h3FF));
      do_write(wword(0, 3, 10'h000));
      do_read(wword(0, 3, 10'h000), "R7 sel3 reads zero");
      do_write(wword(0, 18, 10'h000));
      do_read(wword(0, 18, 10'h3FF), "R7 neighbour untouched");
   endtask

   task automatic t_idle;
      @(negedge clk);
      check(rd_valid === 1'b0, "R8 no read valid low", {15'b0, rd_valid}, 16'h0000);
      check(rd_data === 16'h0000, "R8 idle data zero", rd_data, 16'h0000);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      wr_en = 1'b1; wr_data = wword(0, 17, 10'h000); rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      check(rd_data === wword(0, 17, 10'h001), "R9 select and read", rd_data, wword(0, 17, 10'h001));
      @(negedge clk);
      wr_en = 1'b1; wr_data = wword(1, 17, 10'h0F0); rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      check(rd_data === wword(0, 17, 10'h0F0), "R9 write and read", rd_data, wword(0, 17, 10'h0F0));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_idle();
            t_gp_write();
            t_select_only();
            t_sel_hold();
            t_spare();
            t_irq();
            t_unimpl();
            t_same_cycle();
            t_idle();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule